// File: doc/BRIEF.md
# Masked-Write GPIO Bank

This block is one general-purpose I/O bank of up to 32 pins, controlled through a simple synchronous register bus. Each pin has a direction bit, where 1 selects output and 0 selects input, and an output-enable bit. A pin drives its pad only when both bits are set. Pad inputs pass through a two-flop synchroniser and can always be read back, whatever the pin's direction.

Output levels are never written as a whole word. Software uses one of two write-only ports, each serving half of the bank. Bits 31:16 of the written word form a per-pin mask and bits 15:0 carry the data. A data bit reaches its pin only when the matching mask bit is 0. This lets one pin change without a read-modify-write, so two agents that update different pins cannot undo each other's changes.

The pin count is a parameter. When it is below 32, the bits for the missing pins read as 0 and ignore writes. Read data is registered: the value for the address presented at a clock edge appears after that edge.

Top module: `gpio_bank`

## Requirements
- R1: After reset, the output levels, the direction bits and the output-enable bits are all 0, so no pad is driven.
- R2: A write to offset 0x000 updates pin i (i in 0..15) to data bit i only when mask bit 16+i is 0. Pins whose mask bit is 1 keep their level, and without such a write the output levels never change.
- R3: A write to offset 0x004 updates pin 16+i to data bit i only when mask bit 16+i is 0.
- R4: A write to either half-port leaves every pin of the other half unchanged.
- R5: The direction register at offset 0x204 is read/write, one bit per pin, with 1 meaning output.
- R6: The output-enable register at offset 0x208 is read/write, one bit per pin.
- R7: pad_oe_o for pin i is 1 exactly when its direction bit and its output-enable bit are both 1.
- R8: A read of offset 0x060 returns the pad inputs for every pin, whatever its direction, after a two-flop synchroniser. A pad change made before clock edge k becomes visible in read data returned by a read that samples edge k+2.
- R9: The two half-ports read as 0. Reads of unmapped offsets return 0, and writes to unmapped offsets change no register.
- R10: With NUM_PINS below 32, register bits at and above NUM_PINS read as 0 and ignore writes.
- R11: rdata_o is registered and shows, after clock edge k, the register selected by addr_i at edge k, holding its value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register byte offset |
| we_i | input | 1 | Write strobe for the current cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pad_in_i | input | NUM_PINS | Pad input levels (asynchronous) |
| pad_out_o | output | NUM_PINS | Output level per pin |
| pad_oe_o | output | NUM_PINS | Pad drive enable per pin |

## Verification
The assertions check on every cycle that the output levels change only on a half-port write, and that such a write leaves the other half alone and does nothing when all its mask bits are set. They also check that drive enable never appears without both configuration bits, that direction and enable hold when they are not addressed, and that write-only or unmapped reads and unimplemented bits return 0. Only the bench scenarios can show the actual values selected by partial masks, the mapping of high-port data bits onto pins 16 and up, and the exact synchroniser latency on input reads. The same holds for the truncation a 22-pin instance applies to the same bus traffic.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned HALF_W = 16;

  localparam logic [BUS_W-1:0] OFS_OUT_LO = 32'h000;
  localparam logic [BUS_W-1:0] OFS_OUT_HI = 32'h004;
  localparam logic [BUS_W-1:0] OFS_IN     = 32'h060;
  localparam logic [BUS_W-1:0] OFS_DIR    = 32'h204;
  localparam logic [BUS_W-1:0] OFS_OE     = 32'h208;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_OUT_LO,
    SEL_OUT_HI,
    SEL_IN,
    SEL_DIR,
    SEL_OE
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [BUS_W-1:0] a);
    case (a)
      OFS_OUT_LO: return SEL_OUT_LO;
      OFS_OUT_HI: return SEL_OUT_HI;
      OFS_IN:     return SEL_IN;
      OFS_DIR:    return SEL_DIR;
      OFS_OE:     return SEL_OE;
      default:    return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  reg_sel_e            sel_i,
  input  logic                we_i,
  input  logic [BUS_W-1:0]    wdata_i,
  output logic [NUM_PINS-1:0] out_o,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] oe_o
);
  logic [NUM_PINS-1:0] out_q, dir_q, oe_q;
  logic [NUM_PINS-1:0] upd, nxt;

  // per pin: which half-port owns it and which data/mask bits serve it
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    localparam int unsigned BIT = g % HALF_W;
    localparam reg_sel_e PORT = (g < HALF_W) ? SEL_OUT_LO : SEL_OUT_HI;
    assign upd[g] = we_i && (sel_i == PORT) && !wdata_i[HALF_W+BIT];
    assign nxt[g] = wdata_i[BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      dir_q <= '0;
      oe_q  <= '0;
    end else begin
      out_q <= (out_q & ~upd) | (nxt & upd);
      if (we_i && sel_i == SEL_DIR) dir_q <= wdata_i[NUM_PINS-1:0];
      if (we_i && sel_i == SEL_OE)  oe_q  <= wdata_i[NUM_PINS-1:0];
    end
  end

  assign out_o = out_q;
  assign dir_o = dir_q;
  assign oe_o  = oe_q;
endmodule

// File: rtl/gpio_bank_rd.sv
module gpio_bank_rd
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  reg_sel_e            sel_i,
  input  logic [NUM_PINS-1:0] in_i,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] oe_i,
  output logic [BUS_W-1:0]    rdata_o
);
  logic [BUS_W-1:0] rd_d, rdata_q;

  always_comb begin
    case (sel_i)
      SEL_IN:  rd_d = BUS_W'(in_i);
      SEL_DIR: rd_d = BUS_W'(dir_i);
      SEL_OE:  rd_d = BUS_W'(oe_i);
      default: rd_d = '0; // half-ports are write-only
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o
);
  reg_sel_e            sel;
  logic [NUM_PINS-1:0] in_sync, out_q, dir_q, oe_q;

  assign sel = decode_addr(BUS_W'(addr_i));

  gpio_bank_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (in_sync)
  );

  gpio_bank_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .we_i   (we_i),
    .wdata_i(wdata_i),
    .out_o  (out_q),
    .dir_o  (dir_q),
    .oe_o   (oe_q)
  );

  gpio_bank_rd #(.NUM_PINS(NUM_PINS)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .in_i   (in_sync),
    .dir_i  (dir_q),
    .oe_i   (oe_q),
    .rdata_o(rdata_o)
  );

  assign pad_out_o = out_q;
  assign pad_oe_o  = dir_q & oe_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 12
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                we_i,
  input logic [31:0]         wdata_i,
  input logic [31:0]         rdata_o,
  input logic [NUM_PINS-1:0] pad_out_o,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic [NUM_PINS-1:0] dir_q,
  input logic [NUM_PINS-1:0] oe_q
);
  localparam logic [31:0] PIN_MASK = 32'((64'd1 << NUM_PINS) - 64'd1);

  reg_sel_e    sel;
  logic [31:0] po;
  logic        port_wr;

  assign sel     = decode_addr(BUS_W'(addr_i));
  assign po      = BUS_W'(pad_out_o);
  assign port_wr = we_i && (sel == SEL_OUT_LO || sel == SEL_OUT_HI);

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_wr |=> $stable(pad_out_o));

  p_full_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_wr && wdata_i[31:16] == 16'hFFFF) |=> $stable(pad_out_o));

  p_lo_keeps_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == SEL_OUT_LO) |=> $stable(po[31:16]));

  p_hi_keeps_lo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == SEL_OUT_HI) |=> $stable(po[15:0]));

  p_dir_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && sel == SEL_DIR) |=> $stable(dir_q));

  p_oe_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && sel == SEL_OE) |=> $stable(oe_q));

  p_drive_needs_cfg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o & ~dir_q) == '0) && ((pad_oe_o & ~oe_q) == '0));

  p_wo_read_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_OUT_LO || sel == SEL_OUT_HI || sel == SEL_NONE) |=> rdata_o == '0);

  p_unused_bits_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~PIN_MASK) == '0);
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .we_i     (we_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .pad_out_o(pad_out_o),
  .pad_oe_o (pad_oe_o),
  .dir_q    (dir_q),
  .oe_q     (oe_q)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  localparam int CLK_PERIOD = 10;
  localparam int N_NARROW   = 22;
  localparam logic [31:0] M22 = 32'h003F_FFFF;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] pad_in = '0;
  logic [31:0] rdata, pad_out, pad_oe;
  logic [31:0] rdata_n;
  logic [N_NARROW-1:0] pad_out_n, pad_oe_n;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gpio_bank #(.NUM_PINS(32), .ADDR_W(12)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  gpio_bank #(.NUM_PINS(N_NARROW), .ADDR_W(12)) dut_n (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata_n), .pad_in_i(pad_in[N_NARROW-1:0]), .pad_out_o(pad_out_n),
    .pad_oe_o(pad_oe_n)
  );

  // kind: 0 rdata, 1 pad_out, 2 pad_oe, 3 rdata narrow, 4 pad_out narrow, 5 pad_oe narrow
  typedef struct packed {
    int          due;
    logic [2:0]  kind;
    logic [31:0] exp;
    logic [7:0]  req;
  } item_t;

  item_t q[$];
  item_t it;
  int cyc = 0, total = 0, bad = 0;
  logic [31:0] m_out = '0, m_dir = '0, m_oe = '0;
  logic [31:0] act;
  bit done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor: pops every item that has fallen due and compares it
  always @(negedge clk_i) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      it = q.pop_front();
      case (it.kind)
        3'd0: act = rdata;
        3'd1: act = pad_out;
        3'd2: act = pad_oe;
        3'd3: act = rdata_n;
        3'd4: act = 32'(pad_out_n);
        default: act = 32'(pad_oe_n);
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL R%0d kind=%0d actual=%h expected=%h cyc=%0d",
                 it.req, it.kind, act, it.exp, cyc);
      end
    end
  end

  task automatic push(input logic [2:0] kind, input logic [31:0] exp, input int req);
    item_t n;
    n.due = cyc + 1; n.kind = kind; n.exp = exp; n.req = 8'(req);
    q.push_back(n);
  endtask

  task automatic push_pads(input int req);
    push(3'd1, m_out, req);
    push(3'd2, m_dir & m_oe, 7); // R7 drive enable rule
    push(3'd4, m_out & M22, 10);
    push(3'd5, m_dir & m_oe & M22, 10);
  endtask

  // driver tasks: called at a falling edge, return at the next falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d, input int req);
    addr = a; we = 1'b1; wdata = d;
    case (a)
      12'h000: for (int i = 0; i < 16; i++) if (!d[16+i]) m_out[i] = d[i];
      12'h004: for (int i = 0; i < 16; i++) if (!d[16+i]) m_out[16+i] = d[i];
      12'h204: m_dir = d;
      12'h208: m_oe = d;
      default: ;
    endcase
    push_pads(req);
    @(negedge clk_i);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input int req);
    addr = a; we = 1'b0;
    push(3'd0, exp, req);
    push(3'd3, exp & M22, 10);
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    addr = 12'h100; we = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    push_pads(1);
    rd(12'h204, 32'h0, 1);
    rd(12'h208, 32'h0, 1);
    // R2 low half, all mask bits clear
    wr(12'h000, 32'h0000_FFFF, 2);
    // R2 single pin update: only pin 0 cleared
    wr(12'h000, 32'hFFFE_0000, 2);
    // R3 high half pattern
    wr(12'h004, 32'h0000_A5A5, 3);
    // R3 single pin: data bit 7 -> pin 23
    wr(12'h004, 32'hFF7F_0080, 3);
    // R2 fully masked write changes nothing
    wr(12'h000, 32'hFFFF_1234, 2);
    // R4 partial masks in each half
    wr(12'h000, 32'h00FF_0000, 4);
    wr(12'h004, 32'hF0F0_0F0F, 4);
    // R5 direction, R6 enable, R7 drive rule
    wr(12'h204, 32'hF0F0_00FF, 5);
    rd(12'h204, 32'hF0F0_00FF, 5);
    wr(12'h208, 32'h0FF0_0F0F, 6);
    rd(12'h208, 32'h0FF0_0F0F, 6);
    // R11 read returns value before a same-edge write
    addr = 12'h204; we = 1'b1; wdata = 32'h1234_5678;
    push(3'd0, m_dir, 11);
    m_dir = 32'h1234_5678;
    push_pads(11);
    @(negedge clk_i); we = 1'b0;
    rd(12'h204, 32'h1234_5678, 11);
    // R9 write-only and unmapped reads, unmapped writes
    rd(12'h000, 32'h0, 9);
    rd(12'h004, 32'h0, 9);
    wr(12'h100, 32'hFFFF_FFFF, 9);
    rd(12'h100, 32'h0, 9);
    rd(12'h204, 32'h1234_5678, 9);
    rd(12'h208, 32'h0FF0_0F0F, 9);
    // R8 synchronised input, regardless of direction
    pad_in = 32'hCAFE_F00D;
    idle(2);
    rd(12'h060, 32'hCAFE_F00D, 8);
    pad_in = 32'h1357_9BDF;
    idle(1);
    rd(12'h060, 32'hCAFE_F00D, 8);
    rd(12'h060, 32'h1357_9BDF, 8);
    // R10 narrow bank truncation
    wr(12'h204, 32'hFFFF_FFFF, 10);
    rd(12'h204, 32'hFFFF_FFFF, 10);
    wr(12'h004, 32'h0000_FFFF, 10);
    wr(12'h208, 32'hFFFF_FFFF, 10);
    rd(12'h208, 32'hFFFF_FFFF, 10);
    idle(3);
    if (q.size() != 0) begin
      bad++; total++;
      $display("FAIL scoreboard left %0d unchecked items", q.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule